// File: doc/BRIEF.md
# Execution Mode and Operand/Address Size Decoder

This block turns three mode-selection bits and three already-decoded prefix flags into one execution-mode code. It also produces the effective operand size and effective address size for the current instruction. The three mode bits are a global long-mode-enable flag, plus a "long" bit and a "default-size" bit taken from the active code-segment descriptor. The three prefix flags are a 64-bit operand request, an operand-size override and an address-size override. The block also raises a fault flag when the descriptor bits form the one reserved combination. It raises an address-limit flag when the mode restricts virtual addresses to the lowest 4 GiB.

The decode is purely combinational. A parameter chooses whether the results leave the block directly or through one pipeline register with a synchronous, active-low reset. Downstream decode and address-generation logic consumes the mode code and the two size codes.

Top module: `xmode_decoder`

## Requirements
- R1: With `lm_en_i`=0 the mode code is 0 when `seg_dflt_i`=0 and 1 when `seg_dflt_i`=1, whatever the value of `seg_long_i`.
- R2: With `lm_en_i`=1, `seg_long_i`=1 and `seg_dflt_i`=0, the mode code is 4.
- R3: With `lm_en_i`=1, `seg_long_i`=1 and `seg_dflt_i`=1, the mode code is 7 and `rsvd_fault_o`=1. Both size outputs are then code 1 (32 bits), whatever the prefixes are. `rsvd_fault_o` is 0 for every other combination.
- R4: With `lm_en_i`=1 and `seg_long_i`=0, the mode code is 2 when `seg_dflt_i`=0 and 3 when `seg_dflt_i`=1.
- R5: In mode 4 the operand-size code (0=16, 1=32, 2=64 bits) is set as follows. It is 2 whenever `pfx_w64_i`=1, even if `pfx_opsz_i`=1. Otherwise it is 0 when `pfx_opsz_i`=1, and 1 when no prefix is given.
- R6: In mode 4 the address-size code (same encoding) is 2 by default, and 1 when `pfx_adsz_i`=1.
- R7: In modes 0 to 3 the default size for both operand and address is 32 bits (code 1) when `seg_dflt_i`=1, else 16 bits (code 0). `pfx_opsz_i` flips the operand size between 16 and 32 bits. `pfx_adsz_i` flips the address size between 16 and 32 bits. `pfx_w64_i` has no effect.
- R8: `addr_lim4g_o` is 1 exactly in modes 2 and 3.
- R9: With `REG_OUT`=1 every output shows the decode of the inputs sampled at the previous rising clock edge. While `rst_n` is low the outputs are held at mode 0, both size codes 0, and both flags 0. With `REG_OUT`=0 the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| lm_en_i | input | 1 | Global long-mode-enable flag |
| seg_long_i | input | 1 | Long bit from the code-segment descriptor |
| seg_dflt_i | input | 1 | Default-size bit from the code-segment descriptor |
| pfx_w64_i | input | 1 | Decoded request for 64-bit operand size |
| pfx_opsz_i | input | 1 | Decoded operand-size override prefix |
| pfx_adsz_i | input | 1 | Decoded address-size override prefix |
| mode_o | output | 3 | Mode code: 0 legacy16, 1 legacy32, 2 compat16, 3 compat32, 4 long64, 7 reserved |
| op_size_o | output | 2 | Effective operand size code (0=16, 1=32, 2=64) |
| addr_size_o | output | 2 | Effective address size code (0=16, 1=32, 2=64) |
| rsvd_fault_o | output | 1 | Reserved descriptor combination detected |
| addr_lim4g_o | output | 1 | Virtual addresses limited to the lowest 4 GiB |

## Verification
Two sets of events can fall in the same cycle:

- **Reserved encoding with prefixes present.** The reserved-encoding trap and the prefix-driven size selection can both apply at once. The fault must then override every prefix and force both sizes to 32 bits.
- **Conflicting operand prefixes in mode 4.** The 64-bit request and the operand-size override can both be asserted together. The 64-bit request must win.

The bench sweeps all 64 combinations of the six inputs, so both collisions arise with every prefix pattern. An arithmetic model in the bench judges every output field, once on a combinational instance and once, a clock later, on a registered instance.

// File: rtl/xmode_pkg.sv
package xmode_pkg;

   localparam int MODE_W = 3;
   localparam int SIZE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MD_LEG16  = 3'd0,
      MD_LEG32  = 3'd1,
      MD_CMP16  = 3'd2,
      MD_CMP32  = 3'd3,
      MD_LONG64 = 3'd4,
      MD_RSVD   = 3'd7
   } xmode_e;

   typedef enum logic [SIZE_W-1:0] {
      SZ_16 = 2'd0,
      SZ_32 = 2'd1,
      SZ_64 = 2'd2
   } xsize_e;

   typedef struct packed {
      xmode_e mode;
      xsize_e op;
      xsize_e ad;
      logic   fault;
      logic   lim4g;
   } xdec_t;

   localparam xdec_t XDEC_RST = '{mode: MD_LEG16, op: SZ_16, ad: SZ_16,
                                  fault: 1'b0, lim4g: 1'b0};

   function automatic xsize_e flip16_32(input xsize_e s);
      return (s == SZ_16) ? SZ_32 : SZ_16;
   endfunction

endpackage

// File: rtl/xmode_classify.sv
module xmode_classify
   import xmode_pkg::*;
(
   input  logic   lm_en,
   input  logic   seg_long,
   input  logic   seg_dflt,
   output xmode_e mode,
   output logic   fault,
   output logic   lim4g
);

   always_comb begin
      if (!lm_en) begin
         mode = seg_dflt ? MD_LEG32 : MD_LEG16;
      end else if (seg_long) begin
         mode = seg_dflt ? MD_RSVD : MD_LONG64;
      end else begin
         mode = seg_dflt ? MD_CMP32 : MD_CMP16;
      end
   end

   always_comb begin
      fault = 1'b0;
      lim4g = 1'b0;
      unique case (mode)
         MD_RSVD:            fault = 1'b1;
         MD_CMP16, MD_CMP32: lim4g = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/xmode_size_resolve.sv
module xmode_size_resolve
   import xmode_pkg::*;
(
   input  xmode_e mode,
   input  logic   w64,
   input  logic   opsz,
   input  logic   adsz,
   output xsize_e op_size,
   output xsize_e ad_size
);

   xsize_e base;

   always_comb begin
      base = ((mode == MD_LEG32) || (mode == MD_CMP32)) ? SZ_32 : SZ_16;
   end

   always_comb begin
      op_size = SZ_32;
      ad_size = SZ_32;
      case (mode)
         MD_LEG16, MD_LEG32, MD_CMP16, MD_CMP32: begin
            op_size = opsz ? flip16_32(base) : base;
            ad_size = adsz ? flip16_32(base) : base;
         end
         MD_LONG64: begin
            if (w64)       op_size = SZ_64;
            else if (opsz) op_size = SZ_16;
            else           op_size = SZ_32;
            ad_size = adsz ? SZ_32 : SZ_64;
         end
         default: begin
            op_size = SZ_32;
            ad_size = SZ_32;
         end
      endcase
   end

endmodule

// File: rtl/xmode_out_stage.sv
module xmode_out_stage
   import xmode_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  xdec_t d,
   output xdec_t q
);

   generate
      if (REG_OUT != 0) begin : g_reg
         xdec_t q_r;
         always_ff @(posedge clk) begin
            if (!rst_n) q_r <= XDEC_RST;
            else        q_r <= d;
         end
         assign q = q_r;
      end else begin : g_comb
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/xmode_decoder.sv
module xmode_decoder
   import xmode_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lm_en_i,
   input  logic                seg_long_i,
   input  logic                seg_dflt_i,
   input  logic                pfx_w64_i,
   input  logic                pfx_opsz_i,
   input  logic                pfx_adsz_i,
   output logic [MODE_W-1:0]   mode_o,
   output logic [SIZE_W-1:0]   op_size_o,
   output logic [SIZE_W-1:0]   addr_size_o,
   output logic                rsvd_fault_o,
   output logic                addr_lim4g_o
);

   generate
      if ((REG_OUT != 0) && (REG_OUT != 1)) begin : g_bad_param
         $error("xmode_decoder: REG_OUT must be 0 or 1");
      end
   endgenerate

   xmode_e mode_c;
   logic   fault_c;
   logic   lim_c;
   xsize_e op_c;
   xsize_e ad_c;
   xdec_t  dec_c;
   xdec_t  dec_q;

   xmode_classify u_cls (
      .lm_en    (lm_en_i),
      .seg_long (seg_long_i),
      .seg_dflt (seg_dflt_i),
      .mode     (mode_c),
      .fault    (fault_c),
      .lim4g    (lim_c)
   );

   xmode_size_resolve u_size (
      .mode    (mode_c),
      .w64     (pfx_w64_i),
      .opsz    (pfx_opsz_i),
      .adsz    (pfx_adsz_i),
      .op_size (op_c),
      .ad_size (ad_c)
   );

   always_comb begin
      dec_c.mode  = mode_c;
      dec_c.op    = op_c;
      dec_c.ad    = ad_c;
      dec_c.fault = fault_c;
      dec_c.lim4g = lim_c;
   end

   xmode_out_stage #(.REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dec_c),
      .q     (dec_q)
   );

   assign mode_o       = dec_q.mode;
   assign op_size_o    = dec_q.op;
   assign addr_size_o  = dec_q.ad;
   assign rsvd_fault_o = dec_q.fault;
   assign addr_lim4g_o = dec_q.lim4g;

   // R1: long bit has no effect while long mode is off
   a_r1_legacy_only: assert property (@(posedge clk) disable iff (!rst_n)
      !lm_en_i |-> (mode_c == MD_LEG16 || mode_c == MD_LEG32));

   // R3: a fault forces both sizes to 32 bits regardless of prefixes
   a_r3_fault_sizes: assert property (@(posedge clk) disable iff (!rst_n)
      fault_c |-> (op_c == SZ_32 && ad_c == SZ_32));

   // R5: 64-bit request wins over the operand override in mode 4
   a_r5_w64_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_c == MD_LONG64 && pfx_w64_i) |-> (op_c == SZ_64));

   // R6: no 16-bit address in mode 4
   a_r6_addr_long: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_c == MD_LONG64) |-> (ad_c != SZ_16));

   // R7: 64-bit sizes never appear outside mode 4
   a_r7_no64_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_c != MD_LONG64) |-> (op_c != SZ_64 && ad_c != SZ_64));

   // R8: limit flag and fault flag never together
   a_r8_lim_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(lim_c && fault_c));

   generate
      if (REG_OUT != 0) begin : g_pipe_chk
         // R9: registered outputs carry the previous cycle's decode
         a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (dec_q == $past(dec_c)));
      end
   endgenerate

endmodule

// File: tb/tb_xmode_decoder.sv
module tb_xmode_decoder;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lm, sl, sd, w64, ops, ads;

   logic [2:0] m_r, m_c;
   logic [1:0] op_r, op_c, ad_r, ad_c;
   logic       f_r, f_c, l_r, l_c;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   xmode_decoder #(.REG_OUT(1)) dut (
      .clk(clk), .rst_n(rst_n),
      .lm_en_i(lm), .seg_long_i(sl), .seg_dflt_i(sd),
      .pfx_w64_i(w64), .pfx_opsz_i(ops), .pfx_adsz_i(ads),
      .mode_o(m_r), .op_size_o(op_r), .addr_size_o(ad_r),
      .rsvd_fault_o(f_r), .addr_lim4g_o(l_r)
   );

   xmode_decoder #(.REG_OUT(0)) dut_c (
      .clk(clk), .rst_n(rst_n),
      .lm_en_i(lm), .seg_long_i(sl), .seg_dflt_i(sd),
      .pfx_w64_i(w64), .pfx_opsz_i(ops), .pfx_adsz_i(ads),
      .mode_o(m_c), .op_size_o(op_c), .addr_size_o(ad_c),
      .rsvd_fault_o(f_c), .addr_lim4g_o(l_c)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d (lm=%0b l=%0b d=%0b w=%0b o=%0b a=%0b)",
                  tag, act, exp, lm, sl, sd, w64, ops, ads);
      end
   endtask

   task automatic model(input logic [5:0] v, output int m, output int op,
                        output int ad, output int f, output int lim);
      int base;
      if (!v[0])     m = v[2] ? 1 : 0;
      else if (v[1]) m = v[2] ? 7 : 4;
      else           m = v[2] ? 3 : 2;
      f   = (m == 7) ? 1 : 0;
      lim = (m == 2 || m == 3) ? 1 : 0;
      base = v[2] ? 1 : 0;
      if (m == 7) begin
         op = 1; ad = 1;
      end else if (m == 4) begin
         op = v[3] ? 2 : (v[4] ? 0 : 1);
         ad = v[5] ? 1 : 2;
      end else begin
         op = base ^ int'(v[4]);
         ad = base ^ int'(v[5]);
      end
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int em, eo, ea, ef, el;
      string mt, ot, at;
      {lm, sl, sd, w64, ops, ads} = 6'b110_111;
      repeat (3) @(posedge clk);
      #1;
      // R9: reset values of the registered variant
      chk("R9 reset mode", m_r, 0);
      chk("R9 reset op",   op_r, 0);
      chk("R9 reset addr", ad_r, 0);
      chk("R9 reset fault", f_r, 0);
      chk("R9 reset lim",  l_r, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 64; i++) begin
         logic [5:0] v;
         v = 6'(i);
         @(negedge clk);
         {ads, ops, w64, sd, sl, lm} = v;
         model(v, em, eo, ea, ef, el);
         mt = !v[0] ? "R1 mode" : (v[1] ? (v[2] ? "R3 mode" : "R2 mode") : "R4 mode");
         ot = (em == 7) ? "R3 op"   : ((em == 4) ? "R5 op"   : "R7 op");
         at = (em == 7) ? "R3 addr" : ((em == 4) ? "R6 addr" : "R7 addr");
         #2;
         chk(mt, m_c, em);
         chk(ot, op_c, eo);
         chk(at, ad_c, ea);
         chk("R3 fault", f_c, ef);
         chk("R8 lim", l_c, el);
         @(posedge clk);
         #1;
         // R9: registered variant shows the same decode one edge later
         chk("R9 mode",  m_r, em);
         chk("R9 op",    op_r, eo);
         chk("R9 addr",  ad_r, ea);
         chk("R9 fault", f_r, ef);
         chk("R9 lim",   l_r, el);
      end
      // R9: synchronous reset clears registered outputs after a fault state
      @(negedge clk);
      {lm, sl, sd} = 3'b111;
      @(posedge clk); #1;
      chk("R9 pre-reset fault", f_r, 1);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk); #1;
      chk("R9 reset fault", f_r, 0);
      chk("R9 reset mode", m_r, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule